// File: doc/BRIEF.md
# Packed Lane Compare and Arithmetic Unit

This block is a 64-bit packed-data ALU slice. Each request carries two operands, a lane size of 8, 16 or 32 bits and an operation code. The 64-bit word is split into independent lanes of that size and the same operation runs on every lane: an equality test, signed or unsigned greater-than, signed or unsigned minimum and maximum, wrapping addition and subtraction, or a halving average with optional rounding.

Besides the packed result, the unit produces a 32-bit flag word that reports a negative bit and a zero bit for each lane. Where these bits sit depends on the lane size. A strobe captures the result and the flags into one output register, and they appear together one cycle later. All three lane sizes are computed side by side, and the lane-size select picks one of them.

Top module: `pk_lane_alu`

## Requirements
- R1: Opcode 0 (equality) sets every bit of a lane to 1 when the lanes of op_a and op_b are equal, and clears the lane otherwise.
- R2: Opcode 1 (signed greater-than) and opcode 2 (unsigned greater-than) set a lane to all ones when the op_a lane is greater than the op_b lane under that ordering, and to zero otherwise.
- R3: Opcodes 3 (signed min), 4 (unsigned min), 5 (signed max) and 6 (unsigned max) copy the chosen lane of op_a or op_b to the result without change.
- R4: Opcode 7 (add) and opcode 8 (op_a minus op_b) wrap modulo 2 to the power of the lane width and never saturate.
- R5: Opcode 9 (average) returns (a + b + round_up) >> 1 for each lane, computed one bit wider than the lane so that no carry is lost. round_up is 0 or 1. The operation exists for lane_sel 0 (8-bit) and 1 (16-bit) only.
- R6: lane_sel 0 selects 8-bit lanes, 1 selects 16-bit lanes and 2 selects 32-bit lanes. Lane k of width L owns flag bits k*L/2 through k*L/2+L/2-1. Its top bit is the negative flag, which equals the lane's top result bit. The bit below it is the zero flag, which is set when the whole lane result is zero. For 8-bit lanes this puts N at 4k+3 and Z at 4k+2.
- R7: The average operation writes only zero flags. All negative flag bits are 0 after an average.
- R8: Every flag bit that is not a negative or zero position is 0. These are the two low bits of each 4-bit group of the flag word, so flags & 0x33333333 is always 0.
- R9: A cycle with in_valid high loads res and flags, and they appear after the next rising clock edge with out_valid high. When in_valid is low, res and flags hold their values and out_valid is low.
- R10: lane_sel 3, any opcode above 9, and opcode 9 with lane_sel 2 are illegal. An illegal request yields a zero result and a zero flag word.
- R11: After reset, res, flags and out_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request strobe; loads the output register |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| lane_sel | input | 2 | Lane size: 0 = 8, 1 = 16, 2 = 32, 3 = illegal |
| opcode | input | 4 | Operation code 0 to 9 (see R1 to R5) |
| round_up | input | 1 | Rounding increment for the average |
| out_valid | output | 1 | Result and flags were loaded in the previous cycle |
| res | output | 64 | Packed result |
| flags | output | 32 | Per-lane negative and zero flags |

## Verification
Two functions can meet in one cycle: the output register presents the previous result while a new strobe replaces it. The bench provokes this by issuing requests on every consecutive cycle across the whole sweep of sizes, opcodes, rounding values and operand patterns, including the illegal combinations. Each output is compared against the request issued one cycle earlier, never against the one being driven at that moment. A final idle cycle with new operands on the inputs confirms that the register keeps the last result when no strobe arrives.

// File: rtl/pk_alu_pkg.sv
package pk_alu_pkg;

  typedef enum logic [3:0] {
    OP_EQ   = 4'd0,
    OP_GTS  = 4'd1,
    OP_GTU  = 4'd2,
    OP_MINS = 4'd3,
    OP_MINU = 4'd4,
    OP_MAXS = 4'd5,
    OP_MAXU = 4'd6,
    OP_ADD  = 4'd7,
    OP_SUB  = 4'd8,
    OP_AVG  = 4'd9
  } pk_op_e;

  localparam logic [3:0] OP_LAST = 4'd9;

  // Opcode lies in the defined range
  function automatic logic op_known(input logic [3:0] code);
    return code <= OP_LAST;
  endfunction

endpackage

// File: rtl/pk_lane_engine.sv
module pk_lane_engine
  import pk_alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int FLAG_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [3:0]        op_i,
  input  logic              rnd_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FLAG_W-1:0] flg_o,
  output logic              bad_o
);
  localparam int  NLANE  = DATA_W / LANE_W;
  localparam int  FW     = FLAG_W / NLANE;
  localparam bit  AVG_OK = (LANE_W <= 16);

  function automatic logic gt_signed(input logic [LANE_W-1:0] x, input logic [LANE_W-1:0] y);
    return $signed(x) > $signed(y);
  endfunction

  function automatic logic gt_unsigned(input logic [LANE_W-1:0] x, input logic [LANE_W-1:0] y);
    return x > y;
  endfunction

  function automatic logic [LANE_W-1:0] avg_half(input logic [LANE_W-1:0] x,
                                                 input logic [LANE_W-1:0] y,
                                                 input logic r);
    logic [LANE_W:0] sum;
    sum = {1'b0, x} + {1'b0, y} + {{LANE_W{1'b0}}, r};
    return sum[LANE_W:1];
  endfunction

  function automatic logic [LANE_W-1:0] lane_calc(input logic [3:0] op,
                                                  input logic [LANE_W-1:0] x,
                                                  input logic [LANE_W-1:0] y,
                                                  input logic r);
    case (op)
      OP_EQ:   return (x == y) ? {LANE_W{1'b1}} : '0;
      OP_GTS:  return gt_signed(x, y) ? {LANE_W{1'b1}} : '0;
      OP_GTU:  return gt_unsigned(x, y) ? {LANE_W{1'b1}} : '0;
      OP_MINS: return gt_signed(x, y) ? y : x;
      OP_MINU: return gt_unsigned(x, y) ? y : x;
      OP_MAXS: return gt_signed(x, y) ? x : y;
      OP_MAXU: return gt_unsigned(x, y) ? x : y;
      OP_ADD:  return x + y;
      OP_SUB:  return x - y;
      OP_AVG:  return avg_half(x, y, r);
      default: return '0;
    endcase
  endfunction

  logic is_avg;
  assign is_avg = (op_i == OP_AVG);
  assign bad_o  = !op_known(op_i) || (is_avg && !AVG_OK);

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [LANE_W-1:0] x, y, r;
    logic              nf, zf;
    assign x  = a_i[i*LANE_W +: LANE_W];
    assign y  = b_i[i*LANE_W +: LANE_W];
    assign r  = bad_o ? '0 : lane_calc(op_i, x, y, rnd_i);
    assign nf = !bad_o && !is_avg && r[LANE_W-1];
    assign zf = !bad_o && (r == '0);
    assign res_o[i*LANE_W +: LANE_W] = r;
    assign flg_o[i*FW +: FW]         = {nf, zf, {(FW-2){1'b0}}};
  end

endmodule

// File: rtl/pk_size_mux.sv
module pk_size_mux #(
  parameter int DATA_W = 64,
  parameter int FLAG_W = 32,
  parameter int NSIZE  = 3,
  parameter int SEL_W  = 2
) (
  input  logic [DATA_W-1:0] res_all [NSIZE],
  input  logic [FLAG_W-1:0] flg_all [NSIZE],
  input  logic              bad_all [NSIZE],
  input  logic [SEL_W-1:0]  sel_i,
  output logic [DATA_W-1:0] res_o,
  output logic [FLAG_W-1:0] flg_o,
  output logic              bad_o
);
  always_comb begin
    res_o = '0;
    flg_o = '0;
    bad_o = 1'b1;
    for (int s = 0; s < NSIZE; s++) begin
      if (sel_i == SEL_W'(s)) begin
        bad_o = bad_all[s];
        if (!bad_all[s]) begin
          res_o = res_all[s];
          flg_o = flg_all[s];
        end
      end
    end
  end
endmodule

// File: rtl/pk_out_reg.sv
module pk_out_reg #(
  parameter int DATA_W = 64,
  parameter int FLAG_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_i,
  input  logic [DATA_W-1:0] res_d,
  input  logic [FLAG_W-1:0] flg_d,
  output logic [DATA_W-1:0] res_q,
  output logic [FLAG_W-1:0] flg_q,
  output logic              vld_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      flg_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= ld_i;
      if (ld_i) begin
        res_q <= res_d;
        flg_q <= flg_d;
      end
    end
  end
endmodule

// File: rtl/pk_lane_alu.sv
module pk_lane_alu #(
  parameter int DATA_W     = 64,
  parameter int FLAG_W     = 32,
  parameter int MIN_LANE_W = 8,
  parameter int NSIZE      = 3,
  parameter int SEL_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] op_a,
  input  logic [DATA_W-1:0] op_b,
  input  logic [SEL_W-1:0]  lane_sel,
  input  logic [3:0]        opcode,
  input  logic              round_up,
  output logic              out_valid,
  output logic [DATA_W-1:0] res,
  output logic [FLAG_W-1:0] flags
);
  logic [DATA_W-1:0] res_all [NSIZE];
  logic [FLAG_W-1:0] flg_all [NSIZE];
  logic              bad_all [NSIZE];

  for (genvar s = 0; s < NSIZE; s++) begin : g_size
    pk_lane_engine #(
      .DATA_W (DATA_W),
      .FLAG_W (FLAG_W),
      .LANE_W (MIN_LANE_W << s)
    ) u_eng (
      .a_i   (op_a),
      .b_i   (op_b),
      .op_i  (opcode),
      .rnd_i (round_up),
      .res_o (res_all[s]),
      .flg_o (flg_all[s]),
      .bad_o (bad_all[s])
    );
  end

  // Named internal events for the checker
  logic [DATA_W-1:0] comb_res;
  logic [FLAG_W-1:0] comb_flg;
  logic              cmd_bad;

  pk_size_mux #(
    .DATA_W (DATA_W),
    .FLAG_W (FLAG_W),
    .NSIZE  (NSIZE),
    .SEL_W  (SEL_W)
  ) u_mux (
    .res_all (res_all),
    .flg_all (flg_all),
    .bad_all (bad_all),
    .sel_i   (lane_sel),
    .res_o   (comb_res),
    .flg_o   (comb_flg),
    .bad_o   (cmd_bad)
  );

  pk_out_reg #(
    .DATA_W (DATA_W),
    .FLAG_W (FLAG_W)
  ) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .ld_i  (in_valid),
    .res_d (comb_res),
    .flg_d (comb_flg),
    .res_q (res),
    .flg_q (flags),
    .vld_q (out_valid)
  );

endmodule

// File: rtl/pk_lane_alu_chk.sv
module pk_lane_alu_chk #(
  parameter int DATA_W = 64,
  parameter int FLAG_W = 32,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] op_a,
  input logic [DATA_W-1:0] op_b,
  input logic [SEL_W-1:0]  lane_sel,
  input logic [3:0]        opcode,
  input logic              out_valid,
  input logic [DATA_W-1:0] res,
  input logic [FLAG_W-1:0] flags,
  input logic              cmd_bad
);
  localparam logic [FLAG_W-1:0] CV_MASK = {(FLAG_W/4){4'h3}};
  localparam logic [FLAG_W-1:0] N8_MASK = {(FLAG_W/4){4'h8}};

  logic illegal_req;
  assign illegal_req = (lane_sel == 2'd3) || (opcode > 4'd9) ||
                       (opcode == 4'd9 && lane_sel == 2'd2);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(res) && $stable(flags))); // R9
  AST_CV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flags & CV_MASK) == '0); // R8
  AST_AVG_NO_NEG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'd9) |=> (flags & N8_MASK) == '0); // R7
  AST_BAD_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && illegal_req) |-> cmd_bad); // R10
  AST_BAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && illegal_req) |=> (res == '0 && flags == '0)); // R10
  AST_EQ_SELF: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'd0 && lane_sel != 2'd3 && op_a == op_b) |=> res == '1); // R1
  AST_ADD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 4'd7 && lane_sel != 2'd3 && op_b == '0) |=> res == $past(op_a)); // R4
endmodule

bind pk_lane_alu pk_lane_alu_chk #(
  .DATA_W (DATA_W),
  .FLAG_W (FLAG_W),
  .SEL_W  (SEL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .op_a      (op_a),
  .op_b      (op_b),
  .lane_sel  (lane_sel),
  .opcode    (opcode),
  .out_valid (out_valid),
  .res       (res),
  .flags     (flags),
  .cmd_bad   (cmd_bad)
);

// File: tb/sim_pk_lane_alu.sv
`timescale 1ns/1ps
module sim_pk_lane_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] op_a = '0;
  logic [63:0] op_b = '0;
  logic [1:0]  lane_sel = '0;
  logic [3:0]  opcode = '0;
  logic        round_up = 1'b0;
  logic        out_valid;
  logic [63:0] res;
  logic [31:0] flags;

  int checks = 0;
  int failures = 0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #4 clk = ~clk;

  pk_lane_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .lane_sel(lane_sel), .opcode(opcode), .round_up(round_up),
    .out_valid(out_valid), .res(res), .flags(flags)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rand();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  // Reference model written from the requirements
  task automatic model(input int op, input int sz, input logic [63:0] a, input logic [63:0] b,
                       input bit r, output logic [63:0] er, output logic [31:0] ef);
    int L, fw;
    logic [63:0] m, sb, x, y, v;
    er = '0; ef = '0;
    if (sz == 3 || op > 9 || (op == 9 && sz == 2)) return;
    L  = 8 << sz;
    fw = L / 2;
    m  = (64'd1 << L) - 64'd1;
    sb = 64'd1 << (L - 1);
    for (int i = 0; i < 64 / L; i++) begin
      x = (a >> (i * L)) & m;
      y = (b >> (i * L)) & m;
      case (op)
        0: v = (x == y) ? m : 64'd0;
        1: v = ((x ^ sb) > (y ^ sb)) ? m : 64'd0;
        2: v = (x > y) ? m : 64'd0;
        3: v = ((x ^ sb) < (y ^ sb)) ? x : y;
        4: v = (x < y) ? x : y;
        5: v = ((x ^ sb) > (y ^ sb)) ? x : y;
        6: v = (x > y) ? x : y;
        7: v = (x + y) & m;
        8: v = (x - y) & m;
        default: v = (x + y + {63'd0, r}) >> 1;
      endcase
      er = er | (v << (i * L));
      if (op != 9 && (v & sb) != 0) ef = ef | (32'd1 << (i * fw + fw - 1));
      if (v == 0)                   ef = ef | (32'd1 << (i * fw + fw - 2));
    end
  endtask

  function automatic string res_tag(input int op, input int sz);
    if (sz == 3 || op > 9 || (op == 9 && sz == 2)) return "R10";
    case (op)
      0: return "R1";
      1, 2: return "R2";
      3, 4, 5, 6: return "R3";
      7, 8: return "R4";
      default: return "R5";
    endcase
  endfunction

  logic [63:0] last_res;
  logic [31:0] last_flg;

  // Drive at a falling edge; the result is checked at the next falling edge
  task automatic run_op(input int op, input int sz, input bit r, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] er;
    logic [31:0] ef;
    string t;
    model(op, sz, a, b, r, er, ef);
    t = res_tag(op, sz);
    op_a = a; op_b = b; opcode = 4'(op); lane_sel = 2'(sz); round_up = r; in_valid = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b1, "R9 out_valid", {63'd0, out_valid}, 64'd1);
    check(res === er, t, res, er);
    if (t == "R10")     check(flags === ef, "R10 flags", {32'd0, flags}, {32'd0, ef});
    else if (op == 9)   check(flags === ef, "R7 flags", {32'd0, flags}, {32'd0, ef});
    else                check(flags === ef, "R6 flags", {32'd0, flags}, {32'd0, ef});
    check((flags & 32'h3333_3333) == 0, "R8 cv bits", {32'd0, flags}, 64'd0);
    last_res = er; last_flg = ef;
  endtask

  bit done = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    @(negedge clk);
    @(negedge clk);
    check(res === 64'd0, "R11 res", res, 64'd0);
    check(flags === 32'd0, "R11 flags", {32'd0, flags}, 64'd0);
    check(out_valid === 1'b0, "R11 out_valid", {63'd0, out_valid}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int sz = 0; sz < 4; sz++) begin
      for (int op = 0; op < 16; op++) begin
        for (int r = 0; r < 2; r++) begin
          for (int p = 0; p < 10; p++) begin
            case (p)
              0: begin a = '0; b = '0; end
              1: begin a = '1; b = '0; end
              2: begin a = {8{8'h80}}; b = {8{8'h7F}}; end
              3: begin a = {8{8'h7F}}; b = {8{8'h80}}; end
              4: begin a = '1; b = '1; end
              5: begin a = next_rand(); b = a; end
              6: begin a = next_rand(); b = a ^ 64'h00FF_0000_FFFF_0000; end
              default: begin a = next_rand(); b = next_rand(); end
            endcase
            run_op(op, sz, bit'(r), a, b);
          end
        end
      end
    end
    // Idle cycle with fresh operands: output must hold (R9)
    in_valid = 1'b0;
    op_a = next_rand(); op_b = next_rand(); opcode = 4'd7; lane_sel = 2'd0;
    @(negedge clk);
    check(out_valid === 1'b0, "R9 idle valid", {63'd0, out_valid}, 64'd0);
    check(res === last_res, "R9 idle hold res", res, last_res);
    check(flags === last_flg, "R9 idle hold flags", {32'd0, flags}, {32'd0, last_flg});
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule